// File: doc/BRIEF.md
# Filtered Low-Voltage Detect Status

This block sits between a pair of supply comparators and the processor bus. One comparator reports that the supply has dropped under the falling trip level. The other reports that it has climbed over the higher rising trip level. Both inputs are synchronized, and the low condition is qualified against the reference clock. A sample clock divided by eight feeds a small counter of consecutive low samples, so a brief dip never raises the flag. Once set, the flag is cleared only by the rising-level comparator. The gap between the two levels acts as hysteresis: the flag simply keeps its value there.

The flag is visible as the top bit of a read-only 8-bit status register at a decoded bus address. It also drives a reset request when the reset-enable option is set. Two option inputs govern behaviour in wait mode. With the power-enable option set, the block keeps filtering while the device waits, and its reset request can wake the device. With that option clear, wait mode freezes the flag and restarts qualification.

Top module: `lvd_status`

## Requirements
- R1: The status register is 8 bits wide. Bit 7 carries the low-voltage flag and bits 6 to 0 read as 0. `bus_rdata` shows the register while `bus_addr` equals the register address (default 0x0F) and shows 0x00 for every other address.
- R2: While `rst_n` is low, and right after it rises, the flag reads 0 and `lvd_rst_req` is 0.
- R3: Asserting `vdd_below_fall` continuously, starting from a cleared flag, sets the flag after exactly 34 clock cycles. This is 2 synchronizer cycles plus four divide-by-8 samples, which falls inside the 32 to 40 cycle qualification window. A low run of 31 cycles or fewer leaves the flag at 0.
- R4: If the low condition drops out for even one cycle before the flag sets, qualification starts again from zero.
- R5: With the block active, asserting `vdd_above_rise` clears the flag 3 cycles later, with no qualification delay.
- R6: While neither comparator is asserted, the flag keeps its previous value, whether that value is 0 or 1.
- R7: While `wait_mode` is 1 and `opt_lvd_pwr` is 0, the flag is frozen, even if the rising comparator is asserted. Any qualification in progress is discarded and restarts from zero once the block is active again.
- R8: While `wait_mode` is 1 and `opt_lvd_pwr` is 1, the block sets and clears the flag exactly as it does outside wait mode.
- R9: `lvd_rst_req` equals the flag ANDed with `opt_lvd_rst`, in the same cycle as the flag. This holds in wait mode too, so that the request can wake the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vdd_below_fall | input | 1 | Asynchronous comparator: supply under the falling trip level |
| vdd_above_rise | input | 1 | Asynchronous comparator: supply over the rising trip level |
| wait_mode | input | 1 | Device is in wait mode |
| opt_lvd_pwr | input | 1 | Option: keep the block active during wait mode |
| opt_lvd_rst | input | 1 | Option: a set flag requests a reset |
| bus_addr | input | ADDR_W (8) | Read address |
| bus_rdata | output | DATA_W (8) | Read data: status register when selected, else 0 |
| lvd_rst_req | output | 1 | Reset request to the reset controller |

## Verification
Comparator changes reach the filter after two synchronizer edges. A flag set therefore appears on the 34th edge after a continuous low begins, and a clear appears on the 3rd edge after the rising comparator asserts. The read data and the reset request follow the flag combinationally, in the same cycle. The bench drives every input on the falling edge and steps a cycle-accurate reference model on the rising edge. It compares both outputs on the next falling edge. Directed checks sample one cycle before and one cycle after each due edge, so an early or late result is reported.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

   // Synchronized comparator pair
   typedef struct packed {
      logic below;   // supply under falling trip level
      logic above;   // supply over rising trip level
   } lvd_cmp_t;

   localparam int unsigned LVD_CMP_W = $bits(lvd_cmp_t);

endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lvd_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("lvd_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/lvd_qual.sv
module lvd_qual #(
   parameter int unsigned DIV_LOG2  = 3,
   parameter int unsigned SET_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic below_s,
   input  logic above_s,
   input  logic active,
   output logic flag
);

   localparam int unsigned CNT_W   = $clog2(SET_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SET_TICKS - 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SET_TICKS);

   if (SET_TICKS < 1) begin : g_bad_ticks
      $error("lvd_qual: SET_TICKS must be at least 1");
   end
   if (DIV_LOG2 > 8) begin : g_bad_div
      $error("lvd_qual: DIV_LOG2 above 8 is not supported");
   end

   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;

   // Sample tick: divider restarts whenever the low condition is absent
   if (DIV_LOG2 == 0) begin : g_no_div
      assign tick = 1'b1;
   end else begin : g_div
      logic [DIV_LOG2-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                div_q <= '0;
         else if (!active || !below_s) div_q <= '0;
         else                       div_q <= div_q + 1'b1;
      end
      assign tick = &div_q;
   end

   // Consecutive low-sample counter, saturating
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active || !below_s) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != CNT_SAT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Flag: clear at once above rising level, set on qualifying sample, else hold
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (active) begin
         if (above_s)
            flag_q <= 1'b0;
         else if (below_s && tick && (cnt_q >= CNT_LAST))
            flag_q <= 1'b1;
      end
   end

   assign flag = flag_q;

   assert_clear_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && above_s) |=> !flag_q);

   assert_frozen_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(flag_q));

   assert_set_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> ($past(below_s) && $past(active)));

   assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!below_s && !above_s) |=> $stable(flag_q));

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_SAT);

endmodule

// File: rtl/lvd_regif.sv
module lvd_regif #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned REG_ADDR = 15,
   parameter int unsigned FLAG_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              flag,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

   if (FLAG_BIT >= DATA_W) begin : g_bad_bit
      $error("lvd_regif: FLAG_BIT must lie inside DATA_W");
   end
   if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("lvd_regif: REG_ADDR does not fit ADDR_W");
   end

   logic hit;
   assign hit = (addr == SEL);

   for (genvar b = 0; b < int'(DATA_W); b++) begin : g_bit
      if (b == int'(FLAG_BIT)) begin : g_flag
         assign rdata[b] = hit & flag;
      end else begin : g_zero
         assign rdata[b] = 1'b0;
      end
   end

   assert_other_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~(DATA_W'(1) << FLAG_BIT)) == '0);

   assert_unselected_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (addr != SEL) |-> (rdata == '0));

endmodule

// File: rtl/lvd_status.sv
module lvd_status #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_LOG2    = 3,
   parameter int unsigned SET_TICKS   = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned REG_ADDR    = 15,
   parameter int unsigned FLAG_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vdd_below_fall,
   input  logic              vdd_above_rise,
   input  logic              wait_mode,
   input  logic              opt_lvd_pwr,
   input  logic              opt_lvd_rst,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              lvd_rst_req
);
   import lvd_pkg::*;

   lvd_cmp_t cmp_raw, cmp_s;
   logic     active;
   logic     flag;

   assign cmp_raw.below = vdd_below_fall;
   assign cmp_raw.above = vdd_above_rise;

   lvd_sync #(.STAGES(SYNC_STAGES), .W(LVD_CMP_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw),
      .q     (cmp_s)
   );

   assign active = !wait_mode || opt_lvd_pwr;

   lvd_qual #(.DIV_LOG2(DIV_LOG2), .SET_TICKS(SET_TICKS)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .below_s (cmp_s.below),
      .above_s (cmp_s.above),
      .active  (active),
      .flag    (flag)
   );

   lvd_regif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR),
      .FLAG_BIT (FLAG_BIT)
   ) u_regif (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .flag  (flag),
      .rdata (bus_rdata)
   );

   assign lvd_rst_req = flag & opt_lvd_rst;

   assert_req_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lvd_rst_req |-> (opt_lvd_rst && (bus_addr != ADDR_W'(REG_ADDR) || bus_rdata[FLAG_BIT])));

   assert_reset_clears_R2: assert property (@(posedge clk)
      !rst_n |=> !lvd_rst_req);

endmodule

// File: tb/sim_lvd_status.sv
module sim_lvd_status;

   localparam logic [7:0] REG = 8'h0F;
   localparam int LOW = 0, MID = 1, HIGH = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       below = 1'b0, above = 1'b0;
   logic       wait_m = 1'b0, pwr = 1'b0, rsten = 1'b0;
   logic [7:0] addr = REG;
   logic [7:0] rdata;
   logic       rreq;

   always #10 clk = ~clk;

   lvd_status u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .vdd_below_fall (below),
      .vdd_above_rise (above),
      .wait_mode      (wait_m),
      .opt_lvd_pwr    (pwr),
      .opt_lvd_rst    (rsten),
      .bus_addr       (addr),
      .bus_rdata      (rdata),
      .lvd_rst_req    (rreq)
   );

   int checks = 0;
   int errors = 0;

   // Reference model state
   logic m_s1b = 1'b0, m_s2b = 1'b0, m_s1a = 1'b0, m_s2a = 1'b0;
   int   m_run = 0;
   logic m_flag = 1'b0;

   function automatic logic [7:0] exp_rdata(logic [7:0] a, logic f);
      return (a == REG) ? {f, 7'b0} : 8'h00;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      if (!rst_n) begin
         m_s1b = 0; m_s2b = 0; m_s1a = 0; m_s2a = 0; m_run = 0; m_flag = 0;
      end else begin
         if (!wait_m || pwr) begin
            if (m_s2b) begin
               if (m_run < 32) m_run++;
               if (m_run >= 32) m_flag = 1'b1;
            end else begin
               m_run = 0;
            end
            if (m_s2a) m_flag = 1'b0;
         end else begin
            m_run = 0;
         end
         m_s2b = m_s1b; m_s2a = m_s1a;
         m_s1b = below; m_s1a = above;
      end
   endtask

   task automatic step(int lvl, string tag);
      below = (lvl == LOW);
      above = (lvl == HIGH);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, rdata, exp_rdata(addr, m_flag));
      chk(tag, {7'b0, rreq}, {7'b0, m_flag & rsten});
   endtask

   task automatic run(int lvl, int n, string tag);
      for (int i = 0; i < n; i++) step(lvl, tag);
   endtask

   function automatic logic flag_now();
      return rdata[7];
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd7341));
      @(negedge clk);
      run(MID, 4, "R2");
      chk("R2", rdata, 8'h00);
      rst_n = 1'b1;
      rsten = 1'b1;
      run(MID, 3, "R2");
      chk("R2", {7'b0, rreq}, 8'h00);

      // R3: short dip of 31 cycles never sets
      run(LOW, 31, "R3");
      run(MID, 40, "R3");
      chk("R3", {7'b0, flag_now()}, 8'h00);

      // R4: broken low run restarts qualification
      run(LOW, 20, "R4");
      run(MID, 1, "R4");
      run(LOW, 30, "R4");
      chk("R4", {7'b0, flag_now()}, 8'h00);
      run(MID, 5, "R4");

      // R3: exact set time
      run(LOW, 33, "R3");
      chk("R3", {7'b0, flag_now()}, 8'h00);
      run(LOW, 1, "R3");
      chk("R3", {7'b0, flag_now()}, 8'h01);
      chk("R9", {7'b0, rreq}, 8'h01);

      // R1: other address reads zero
      addr = 8'h0E;
      step(LOW, "R1");
      chk("R1", rdata, 8'h00);
      addr = REG;
      step(LOW, "R1");
      chk("R1", rdata, 8'h80);

      // R6: hold 1 between levels
      run(MID, 60, "R6");
      chk("R6", {7'b0, flag_now()}, 8'h01);

      // R5: clear after 3 cycles
      run(HIGH, 2, "R5");
      chk("R5", {7'b0, flag_now()}, 8'h01);
      run(HIGH, 1, "R5");
      chk("R5", {7'b0, flag_now()}, 8'h00);

      // R6: hold 0 between levels
      run(MID, 60, "R6");
      chk("R6", {7'b0, flag_now()}, 8'h00);

      // R9: request gated by option
      rsten = 1'b0;
      run(LOW, 40, "R9");
      chk("R9", {7'b0, flag_now()}, 8'h01);
      chk("R9", {7'b0, rreq}, 8'h00);
      rsten = 1'b1;
      step(LOW, "R9");
      chk("R9", {7'b0, rreq}, 8'h01);

      // R7: frozen in wait without power option
      wait_m = 1'b1; pwr = 1'b0;
      run(HIGH, 20, "R7");
      chk("R7", {7'b0, flag_now()}, 8'h01);
      run(MID, 3, "R7");
      wait_m = 1'b0;
      run(HIGH, 5, "R7");
      chk("R7", {7'b0, flag_now()}, 8'h00);
      wait_m = 1'b1;
      run(LOW, 60, "R7");
      chk("R7", {7'b0, flag_now()}, 8'h00);
      wait_m = 1'b0;
      run(LOW, 20, "R7");
      wait_m = 1'b1;
      run(LOW, 5, "R7");
      wait_m = 1'b0;
      run(LOW, 20, "R7");
      chk("R7", {7'b0, flag_now()}, 8'h00);
      run(MID, 5, "R7");

      // R8: active in wait with power option, request wakes
      wait_m = 1'b1; pwr = 1'b1;
      run(LOW, 40, "R8");
      chk("R8", {7'b0, flag_now()}, 8'h01);
      chk("R9", {7'b0, rreq}, 8'h01);
      run(HIGH, 5, "R8");
      chk("R8", {7'b0, flag_now()}, 8'h00);
      wait_m = 1'b0; pwr = 1'b0;

      // Random segments against the model
      for (int s = 0; s < 120; s++) begin
         int lvl;
         int len;
         lvl    = int'($urandom_range(2, 0));
         len    = int'($urandom_range(60, 1));
         wait_m = ($urandom_range(3, 0) == 0);
         pwr    = $urandom_range(1, 0) == 1;
         rsten  = $urandom_range(1, 0) == 1;
         addr   = ($urandom_range(1, 0) == 1) ? REG : 8'($urandom_range(255, 0));
         run(lvl, len, "R3/R5/R6/R7/R9 random");
      end

      summary();
      $finish;
   end

endmodule